// File: doc/BRIEF.md
# SECDED-protected memory path with hardware scrub

This block sits between a host request port and a word-wide memory that stores 72-bit codewords. Every write of a whole 64-bit word is encoded with an (72,64) single-error-correct, double-error-detect code and stored as one codeword. Every read is decoded. Depending on a 2-bit integrity mode, the read data is returned raw or corrected. Single-bit and multi-bit error events are reported as one-cycle pulses carrying the word address.

A write that covers only some byte lanes is turned into a read, a merge and a full re-encoded write whenever checking is on. With checking off, such a write stores only the enabled lanes. In the scrub mode, a corrected read also puts the corrected codeword back into memory. That write takes the next memory slot ahead of any waiting host request, so single-bit faults are cleared before a second fault can land in the same word.

The memory has a one-cycle read latency. Its data lanes 0 to 7 are the eight data bytes and lane 8 is the check byte.

Top module: `secded_mem_path`

## Requirements
- R1: A host write with all eight byte enables set writes the memory in the cycle it is accepted, with mem_we_o high and all nine lanes enabled (mem_be_o = 9'h1FF). The codeword layout is bits [63:0] data, bits [70:64] Hamming check bits and bit 71 overall parity, giving even parity over all 72 bits.
- R2: A read accepted at one clock edge raises rsp_valid_o for exactly one cycle, starting at the following edge. A clean word returns the written data and raises no error event.
- R3: With mode 01, 10 or 11, a read of a word in which any one of the 72 stored bits is flipped raises err_sbe_o for one cycle, together with rsp_valid_o, and err_addr_o carries the word address.
- R4: Mode 10 and mode 11 return corrected data after a single-bit error. Mode 01 returns the stored data bits unchanged.
- R5: Two flipped bits in one word raise err_mbe_o and not err_sbe_o. The stored data is returned uncorrected and no write-back happens.
- R6: In mode 11, a read that reports err_sbe_o writes the re-encoded corrected word to the same address in the next cycle, so a later read of that word is clean. Mode 10 performs no such write, so the fault persists.
- R7: In mode 00 (encoding 00 = none, 01 = detect, 10 = correct, 11 = correct plus scrub), reads return the stored data bits and never raise an error event.
- R8: In modes 01 to 11, a partial write first reads the word. One cycle after the read data returns, it writes the merged word on all nine lanes. The bytes whose enable bit is clear come from the read data, corrected in modes 10 and 11. req_ready_o stays low for the two cycles after acceptance. Any error found on the read is reported.
- R9: In mode 00, a partial write is a single write in the accepting cycle with mem_be_o = {1'b0, req_be_i}, and the block is ready again in the next cycle.
- R10: While a scrub write-back is in progress, req_ready_o is low and the memory address is the scrubbed word. A held host request is accepted only after that cycle.
- R11: err_sbe_o and err_mbe_o are never high together, and each pulse lasts one cycle.
- R12: After reset, req_ready_o is high and rsp_valid_o, err_sbe_o, err_mbe_o and mem_en_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Integrity mode, sampled when a request is accepted |
| req_i | input | 1 | Host request valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_be_i | input | 8 | Byte enables for writes |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | 64 | Write data |
| req_ready_o | output | 1 | Block can accept a request this cycle |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_data_o | output | 64 | Read data |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write |
| mem_be_o | output | 9 | Memory lane enables, lane 8 = check byte |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 72 | Codeword to memory |
| mem_rdata_i | input | 72 | Codeword from memory, one cycle after a read strobe |
| err_sbe_o | output | 1 | Single-bit error event pulse |
| err_mbe_o | output | 1 | Multi-bit error event pulse |
| err_addr_o | output | AW | Word address of the error event |

## Verification
A wrong state-machine state shows up within two cycles of the request. It appears as a missing or doubled rsp_valid_o pulse, a req_ready_o that stays low, or a memory write that is missing or extra in the cycle after a corrected read or a merge. A stale latched mode shows up at the next read as returned data or an error event that does not match the mode in force. A wrong bit mapping in the decoder only shows when the matching bit is flipped, so every one of the 72 positions is faulted and read back. A missed scrub shows as a repeated single-bit event on the following read of that word.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W  = 64;
  localparam int HAM_W   = 7;
  localparam int CODE_W  = DATA_W + HAM_W + 1;
  localparam int LANES   = CODE_W / 8;
  localparam int NBYTES  = DATA_W / 8;

  typedef enum logic [1:0] {
    MODE_RAW   = 2'b00,
    MODE_DET   = 2'b01,
    MODE_COR   = 2'b10,
    MODE_SCRUB = 2'b11
  } imode_e;

  // Hamming position of data bit j: j-th position that is not a power of two
  function automatic int dpos(int j);
    int cnt = 0;
    int r = 0;
    for (int p = 1; p < 128; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == j && r == 0) r = p;
        cnt++;
      end
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] cmask(int i);
    logic [DATA_W-1:0] m = '0;
    for (int j = 0; j < DATA_W; j++) m[j] = ((dpos(j) >> i) & 1) == 1;
    return m;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);
  logic [HAM_W-1:0] chk;

  for (genvar i = 0; i < HAM_W; i++) begin : g_chk
    localparam logic [DATA_W-1:0] M = cmask(i);
    assign chk[i] = ^(data_i & M);
  end

  assign code_o = {^{chk, data_i}, chk, data_i};
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sbe_o,
  output logic              mbe_o
);
  logic [HAM_W-1:0] syn;
  logic             odd;

  for (genvar i = 0; i < HAM_W; i++) begin : g_syn
    localparam logic [DATA_W-1:0] M = cmask(i);
    assign syn[i] = ^(code_i[DATA_W-1:0] & M) ^ code_i[DATA_W+i];
  end

  assign odd   = ^code_i;
  // odd parity with syndrome 0 is a fault in the parity bit itself
  assign sbe_o = odd && (syn < 7'(CODE_W));
  assign mbe_o = (!odd && syn != '0) || (odd && syn >= 7'(CODE_W));

  for (genvar j = 0; j < DATA_W; j++) begin : g_fix
    localparam int P = dpos(j);
    assign data_o[j] = code_i[j] ^ (sbe_o && syn == 7'(P));
  end
endmodule

// File: rtl/secded_mem_path.sv
module secded_mem_path
  import secded_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [NBYTES-1:0] req_be_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [CODE_W-1:0] mem_wdata_o,
  input  logic [CODE_W-1:0] mem_rdata_i,
  output logic              err_sbe_o,
  output logic              err_mbe_o,
  output logic [AW-1:0]     err_addr_o
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_MRG, S_WB} st_e;

  st_e               st_q;
  logic [AW-1:0]     addr_q;
  logic [NBYTES-1:0] be_q;
  logic [DATA_W-1:0] wdata_q, wb_data_q;
  logic [1:0]        mode_q;

  logic              accept, full, need_rmw, checking;
  logic [DATA_W-1:0] corr, rd_data, merged, enc_in;
  logic [CODE_W-1:0] enc_out;
  logic              dec_sbe, dec_mbe, ev_sbe, ev_mbe;

  assign req_ready_o = (st_q == S_IDLE);
  assign accept      = req_i && req_ready_o;
  assign full        = &req_be_i;
  assign need_rmw    = req_we_i && !full && (mode_i != MODE_RAW);

  secded_dec u_dec (
    .code_i (mem_rdata_i),
    .data_o (corr),
    .sbe_o  (dec_sbe),
    .mbe_o  (dec_mbe)
  );

  assign checking = (mode_q != MODE_RAW);
  assign rd_data  = mode_q[1] ? corr : mem_rdata_i[DATA_W-1:0];
  assign ev_sbe   = checking && dec_sbe;
  assign ev_mbe   = checking && dec_mbe;

  always_comb begin
    for (int k = 0; k < NBYTES; k++)
      merged[k*8 +: 8] = be_q[k] ? wdata_q[k*8 +: 8] : rd_data[k*8 +: 8];
  end

  assign enc_in = (st_q == S_WB) ? wb_data_q : req_wdata_i;

  secded_enc u_enc (
    .data_i (enc_in),
    .code_o (enc_out)
  );

  assign mem_wdata_o = enc_out;

  always_comb begin
    mem_en_o   = 1'b0;
    mem_we_o   = 1'b0;
    mem_be_o   = '0;
    mem_addr_o = addr_q;
    unique case (st_q)
      S_IDLE: begin
        mem_addr_o = req_addr_i;
        if (req_i) begin
          mem_en_o = 1'b1;
          if (req_we_i && !need_rmw) begin
            mem_we_o = 1'b1;
            mem_be_o = full ? '1 : {1'b0, req_be_i};
          end
        end
      end
      S_WB: begin
        mem_en_o = 1'b1;
        mem_we_o = 1'b1;
        mem_be_o = '1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      addr_q    <= '0;
      be_q      <= '0;
      wdata_q   <= '0;
      mode_q    <= MODE_RAW;
      wb_data_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (accept) begin
          addr_q  <= req_addr_i;
          be_q    <= req_be_i;
          wdata_q <= req_wdata_i;
          mode_q  <= mode_i;
          st_q    <= !req_we_i ? S_RD : (need_rmw ? S_MRG : S_IDLE);
        end
        S_RD: begin
          wb_data_q <= corr;
          st_q      <= (mode_q == MODE_SCRUB && dec_sbe) ? S_WB : S_IDLE;
        end
        S_MRG: begin
          wb_data_q <= merged;
          st_q      <= S_WB;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      err_sbe_o   <= 1'b0;
      err_mbe_o   <= 1'b0;
      err_addr_o  <= '0;
    end else begin
      rsp_valid_o <= (st_q == S_RD);
      if (st_q == S_RD) rsp_data_o <= rd_data;
      err_sbe_o   <= (st_q == S_RD || st_q == S_MRG) && ev_sbe;
      err_mbe_o   <= (st_q == S_RD || st_q == S_MRG) && ev_mbe;
      err_addr_o  <= addr_q;
    end
  end
endmodule

// File: rtl/secded_mem_path_chk.sv
module secded_mem_path_chk #(
  parameter int AW = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       req_i,
  input logic       req_we_i,
  input logic [7:0] req_be_i,
  input logic       req_ready_o,
  input logic       rsp_valid_o,
  input logic       mem_en_o,
  input logic       mem_we_o,
  input logic [8:0] mem_be_o,
  input logic       err_sbe_o,
  input logic       err_mbe_o,
  input logic [1:0] mode_q
);
  logic acc;
  assign acc = req_i && req_ready_o;

  p_full_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_we_i && (&req_be_i)) |-> (mem_en_o && mem_we_o && mem_be_o == 9'h1FF));

  p_rsp_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !req_we_i) |=> ##1 rsp_valid_o);

  p_rsp_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_scrub_wb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_sbe_o && mode_q == 2'b11) |-> (mem_en_o && mem_we_o && mem_be_o == 9'h1FF && !req_ready_o));

  p_raw_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'b00) |-> (!err_sbe_o && !err_mbe_o));

  p_rmw_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_we_i && !(&req_be_i) && mode_i != 2'b00) |-> (mem_en_o && !mem_we_o));

  p_rmw_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_we_i && !(&req_be_i) && mode_i != 2'b00) |=> ##1 (mem_we_o && mem_be_o == 9'h1FF));

  p_raw_partial_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_we_i && !(&req_be_i) && mode_i == 2'b00) |-> (mem_we_o && mem_be_o == {1'b0, req_be_i}));

  p_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_sbe_o && err_mbe_o));

  p_sbe_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_sbe_o |=> !err_sbe_o);
endmodule

bind secded_mem_path secded_mem_path_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .req_i       (req_i),
  .req_we_i    (req_we_i),
  .req_be_i    (req_be_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .mem_en_o    (mem_en_o),
  .mem_we_o    (mem_we_o),
  .mem_be_o    (mem_be_o),
  .err_sbe_o   (err_sbe_o),
  .err_mbe_o   (err_mbe_o),
  .mode_q      (mode_q)
);

// File: tb/secded_mem_path_test.sv
module secded_mem_path_test;
  localparam int AW = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'b10;
  logic        req_i = 1'b0, req_we_i = 1'b0;
  logic [7:0]  req_be_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic [63:0] req_wdata_i = '0;
  logic        req_ready_o, rsp_valid_o, mem_en_o, mem_we_o, err_sbe_o, err_mbe_o;
  logic [63:0] rsp_data_o;
  logic [8:0]  mem_be_o;
  logic [AW-1:0] mem_addr_o, err_addr_o;
  logic [71:0] mem_wdata_o, mem_rdata_i;

  logic [71:0] ram [64];
  logic        flip_en = 1'b0;
  logic [AW-1:0] flip_addr = '0;
  logic [71:0] flip_mask = '0;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;
  logic obs_en, obs_we;
  logic [8:0] obs_be;
  logic [63:0] shadow [64];

  always #2 clk_i = ~clk_i;

  secded_mem_path #(.AW(AW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .req_i(req_i), .req_we_i(req_we_i),
    .req_be_i(req_be_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_be_o(mem_be_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .err_sbe_o(err_sbe_o),
    .err_mbe_o(err_mbe_o), .err_addr_o(err_addr_o)
  );

  always_ff @(posedge clk_i) begin
    if (flip_en) ram[flip_addr] <= ram[flip_addr] ^ flip_mask;
    else if (mem_en_o) begin
      if (mem_we_o) begin
        for (int k = 0; k < 9; k++)
          if (mem_be_o[k]) ram[mem_addr_o][k*8 +: 8] <= mem_wdata_o[k*8 +: 8];
      end else mem_rdata_i <= ram[mem_addr_o];
    end
  end

  task automatic chk(string tag, logic [71:0] act, logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic flip(logic [AW-1:0] a, logic [71:0] m);
    @(negedge clk_i);
    flip_en = 1'b1; flip_addr = a; flip_mask = m;
    @(negedge clk_i);
    flip_en = 1'b0;
  endtask

  // drive a request, wait for acceptance, capture memory strobe of accept cycle
  task automatic issue(logic we, logic [7:0] be, logic [AW-1:0] a, logic [63:0] d);
    @(negedge clk_i);
    req_i = 1'b1; req_we_i = we; req_be_i = be; req_addr_i = a; req_wdata_i = d;
    while (!req_ready_o) @(negedge clk_i);
    #1;
    obs_en = mem_en_o; obs_we = mem_we_o; obs_be = mem_be_o;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wr_full(logic [AW-1:0] a, logic [63:0] d);
    issue(1'b1, 8'hFF, a, d);
    chk("R1 full write strobe", {obs_en, obs_we, obs_be}, {2'b11, 9'h1FF});
    shadow[a] = d;
  endtask

  task automatic rd(string tag, logic [AW-1:0] a, logic [63:0] exp_d, logic es, logic em, logic ewb);
    issue(1'b0, 8'hFF, a, '0);
    @(negedge clk_i);
    chk({tag, " rsp_valid"}, 72'(rsp_valid_o), 72'(1));
    chk({tag, " data"}, 72'(rsp_data_o), 72'(exp_d));
    chk({tag, " sbe/mbe"}, 72'({err_sbe_o, err_mbe_o}), 72'({es, em}));
    if (es || em) chk({tag, " err_addr"}, 72'(err_addr_o), 72'(a));
    chk({tag, " writeback"}, 72'(mem_en_o && mem_we_o && mem_be_o == 9'h1FF && !req_ready_o), 72'(ewb));
    if (ewb) chk({tag, " writeback addr"}, 72'(mem_addr_o), 72'(a));
    @(negedge clk_i);
    chk({tag, " R11 pulse end"}, 72'({rsp_valid_o, err_sbe_o, err_mbe_o}), 72'(0));
  endtask

  task automatic t_reset;
    chk("R12 ready", 72'(req_ready_o), 72'(1));
    chk("R12 rsp_valid", 72'(rsp_valid_o), 72'(0));
    chk("R12 err", 72'({err_sbe_o, err_mbe_o}), 72'(0));
    chk("R12 mem_en", 72'(mem_en_o), 72'(0));
  endtask

  task automatic t_patterns;
    logic [63:0] p [4];
    p[0] = 64'h0; p[1] = '1; p[2] = 64'hAAAA_5555_AAAA_5555; p[3] = 64'h0123_4567_89AB_CDEF;
    mode_i = 2'b10;
    for (int i = 0; i < 4; i++) wr_full(AW'(i + 1), p[i]);
    for (int i = 0; i < 4; i++) rd("R2 clean read", AW'(i + 1), p[i], 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_single_each;
    logic [63:0] d;
    mode_i = 2'b10;
    for (int b = 0; b < 72; b++) begin
      d = 64'hA5C3_0F1E_9B7D_2468 ^ 64'(b * 64'h0101_0101);
      wr_full(6'd5, d);
      flip(6'd5, 72'(1) << b);
      rd("R3 R4 single fault corrected", 6'd5, d, 1'b1, 1'b0, 1'b0);
    end
    rd("R6 mode 10 keeps fault", 6'd5, d, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_detect;
    logic [63:0] d = 64'hDEAD_BEEF_0BAD_F00D;
    mode_i = 2'b01;
    wr_full(6'd8, d);
    flip(6'd8, 72'(1) << 9);
    rd("R4 detect-only raw", 6'd8, d ^ (64'(1) << 9), 1'b1, 1'b0, 1'b0);
    flip(6'd8, 72'(1) << 50);
    rd("R5 detect-only double", 6'd8, d ^ (64'(1) << 9) ^ (64'(1) << 50), 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_double;
    logic [63:0] d = 64'h1357_9BDF_2468_ACE0;
    int pa [3] = '{3, 0, 64};
    int pb [3] = '{40, 71, 70};
    for (int i = 0; i < 3; i++) begin
      mode_i = (i == 1) ? 2'b11 : 2'b10;
      wr_full(6'd10, d);
      flip(6'd10, (72'(1) << pa[i]) | (72'(1) << pb[i]));
      rd("R5 double fault", 6'd10, d ^ 64'((72'(1) << pa[i]) | (72'(1) << pb[i])), 1'b0, 1'b1, 1'b0);
    end
  endtask

  task automatic t_scrub;
    logic [63:0] d = 64'hFACE_CAFE_1234_5678;
    mode_i = 2'b11;
    wr_full(6'd12, d);
    flip(6'd12, 72'(1) << 33);
    rd("R6 scrub data", 6'd12, d, 1'b1, 1'b0, 1'b1);
    rd("R6 clean after scrub", 6'd12, d, 1'b0, 1'b0, 1'b0);
    flip(6'd12, 72'(1) << 66);
    rd("R6 scrub check bit", 6'd12, d, 1'b1, 1'b0, 1'b1);
    rd("R6 clean after check scrub", 6'd12, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_priority;
    logic [63:0] d = 64'h0F0F_F0F0_3C3C_C3C3, d2 = 64'h7777_1111_2222_3333;
    mode_i = 2'b11;
    wr_full(6'd14, d);
    flip(6'd14, 72'(1) << 60);
    issue(1'b0, 8'hFF, 6'd14, '0);
    req_i = 1'b1; req_we_i = 1'b1; req_be_i = 8'hFF; req_addr_i = 6'd15; req_wdata_i = d2;
    @(negedge clk_i);
    chk("R10 ready low in scrub", 72'(req_ready_o), 72'(0));
    chk("R10 scrub owns memory", 72'({mem_we_o, mem_addr_o}), 72'({1'b1, 6'd14}));
    chk("R10 read data", 72'(rsp_data_o), 72'(d));
    @(negedge clk_i);
    chk("R10 held request accepted after", 72'({req_ready_o, mem_we_o, mem_addr_o}), 72'({2'b11, 6'd15}));
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
    shadow[15] = d2;
    rd("R10 held write stored", 6'd15, d2, 1'b0, 1'b0, 1'b0);
    rd("R10 scrubbed word clean", 6'd14, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_raw;
    logic [63:0] d = 64'h8000_0000_0000_0001;
    mode_i = 2'b00;
    wr_full(6'd16, d);
    flip(6'd16, 72'(1) << 20);
    rd("R7 raw single", 6'd16, d ^ (64'(1) << 20), 1'b0, 1'b0, 1'b0);
    flip(6'd16, 72'(1) << 63);
    rd("R7 raw double", 6'd16, d ^ (64'(1) << 20) ^ (64'(1) << 63), 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_rmw;
    logic [63:0] base = 64'h1122_3344_5566_7788, nd = 64'hAAAA_BBBB_CCCC_DDDD;
    mode_i = 2'b10;
    wr_full(6'd20, base);
    flip(6'd20, 72'(1) << 52);
    issue(1'b1, 8'h0F, 6'd20, nd);
    chk("R8 rmw read first", 72'({obs_en, obs_we}), 72'(2'b10));
    chk("R8 ready low after accept", 72'(req_ready_o), 72'(0));
    @(negedge clk_i);
    chk("R8 merged write", 72'({mem_we_o, mem_be_o, mem_addr_o, req_ready_o}), 72'({1'b1, 9'h1FF, 6'd20, 1'b0}));
    chk("R8 error on merge read", 72'({err_sbe_o, err_mbe_o}), 72'(2'b10));
    @(negedge clk_i);
    rd("R8 merged corrected", 6'd20, {base[63:32], nd[31:0]}, 1'b0, 1'b0, 1'b0);
    mode_i = 2'b01;
    issue(1'b1, 8'hC0, 6'd20, nd);
    @(negedge clk_i);
    chk("R8 mode 01 merge write", 72'({mem_we_o, mem_be_o}), 72'({1'b1, 9'h1FF}));
    @(negedge clk_i);
    rd("R8 mode 01 merged", 6'd20, {nd[63:48], base[47:32], nd[31:0]}, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_raw_partial;
    logic [63:0] base = 64'h0102_0304_0506_0708, nd = 64'hFFEE_DDCC_BBAA_9988;
    mode_i = 2'b00;
    wr_full(6'd24, base);
    issue(1'b1, 8'h30, 6'd24, nd);
    chk("R9 lane write only", 72'({obs_en, obs_we, obs_be}), 72'({2'b11, 9'h030}));
    chk("R9 ready next cycle", 72'(req_ready_o), 72'(1));
    rd("R9 raw merged", 6'd24, {base[63:48], nd[47:32], base[31:0]}, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_patterns();
    t_single_each();
    t_detect();
    t_double();
    t_scrub();
    t_priority();
    t_raw();
    t_rmw();
    t_raw_partial();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule